// File: doc/BRIEF.md
# Optical Disc Mirror Detector

This block watches a stream of sampled RF amplitude values and flags the stretches where the reflected signal swing collapses. That happens while the pickup crosses the mirror-like land between tracks. Each sample, marked by a one-cycle valid strobe, updates two trackers. A peak tracker follows the top of the signal and a bottom tracker follows its floor. Their difference is the instantaneous envelope.

A slow first-order average of the envelope gives an adaptive reference, so the block follows discs and pickups whose RF swing differs. A two-bit sensitivity setting scales the reference down to form the threshold. The flag rises when the envelope falls below that threshold. A second two-bit setting picks how fast the bottom tracker climbs back after a dip. Both settings sit in a four-bit register loaded through a plain write strobe. The one-bit output is registered and changes only on sample strobes, so downstream track-counting logic gets a clean level.

Top module: `mdet_top`

## Requirements
- R1: A synchronous active-high reset clears the flag, sets the peak tracker to 0, the bottom tracker to all ones, the average accumulator to 0, and both settings to 0.
- R2: Trackers, average and flag change only on clock edges where `smp_vld` is high; between strobes `mirror_o` holds its value.
- R3: On a strobe, the peak tracker takes the sample if the sample is greater; otherwise it becomes `peak - ((peak - sample) >> 4)`.
- R4: On a strobe, the bottom tracker takes the sample if the sample is smaller; otherwise it becomes `bottom + ((sample - bottom) >> (2 + speed))`, where speed is `cfg_wdata[3:2]` as last written.
- R5: The envelope is the updated peak minus the updated bottom, and after any strobe the peak tracker is not below the bottom tracker.
- R6: The average is `acc >> 6` of a 14-bit accumulator updated on each strobe as `acc - (acc >> 6) + envelope`.
- R7: The threshold is derived from the average before the current update, using the sensitivity field `cfg_wdata[1:0]`: 0 gives `(a>>1)`, 1 gives `(a>>1)+(a>>3)`, 2 gives `(a>>1)+(a>>2)`, 3 gives `a-(a>>3)`.
- R8: On a strobe edge, `mirror_o` is loaded with 1 when the envelope is strictly below the threshold and 0 otherwise, and it is visible in the cycle after the strobe.
- R9: A write with `cfg_we` high loads the settings at that clock edge; a strobe on the same edge still uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One-cycle strobe marking a new RF sample |
| smp | input | DW (8) | Unsigned RF amplitude sample |
| cfg_we | input | 1 | Settings write enable |
| cfg_wdata | input | 4 | [3:2] bottom-tracker speed, [1:0] sensitivity |
| mirror_o | output | 1 | Registered mirror flag |

## Verification
The assertions assume that reset is asserted from time zero until the first strobe sequence. They also assume that `smp` and `smp_vld` carry known values on every edge after reset, because the tracker-ordering and capture properties compare the sample against the stored holds. The stimulus holds reset high for several cycles before any strobe. It drives every input at the falling clock edge with defined values, and between strobes it parks `smp_vld` low with `smp` at a fixed value. Settings are written only with fully defined four-bit words.

// File: rtl/mdet_pkg.sv
`timescale 1ns/1ps
package mdet_pkg;

    typedef enum logic [1:0] {
        SENS_HALF  = 2'd0,
        SENS_5_8   = 2'd1,
        SENS_3_4   = 2'd2,
        SENS_7_8   = 2'd3
    } sens_e;

    typedef struct packed {
        logic [1:0] speed;
        sens_e      sens;
    } cfg_t;

    localparam int PEAK_DECAY_SHIFT = 4;
    localparam int BOT_BASE_SHIFT   = 2;
    localparam int AVG_SHIFT        = 6;

endpackage

// File: rtl/mdet_hold.sv
`timescale 1ns/1ps
module mdet_hold #(
    parameter int DW          = 8,
    parameter bit TRACK_MAX   = 1'b1,
    parameter int FIXED_SHIFT = 4,
    parameter int BASE_SHIFT  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld,
    input  logic [DW-1:0] smp,
    input  logic [1:0]    rate_sel,
    output logic [DW-1:0] hold_q,
    output logic [DW-1:0] hold_nxt
);
    localparam int SHW = 4;
    localparam logic [DW-1:0] RST_VAL = TRACK_MAX ? {DW{1'b0}} : {DW{1'b1}};

    logic          capture;
    logic [DW-1:0] gap;
    logic [DW-1:0] step;
    logic [SHW-1:0] sh;

    always_comb begin
        sh = TRACK_MAX ? SHW'(FIXED_SHIFT) : SHW'(BASE_SHIFT) + {{(SHW-2){1'b0}}, rate_sel};
    end

    generate
        if (TRACK_MAX) begin : g_peak
            always_comb begin
                capture  = smp > hold_q;
                gap      = hold_q - smp;
                step     = gap >> sh;
                hold_nxt = capture ? smp : (hold_q - step);
            end
        end else begin : g_bottom
            always_comb begin
                capture  = smp < hold_q;
                gap      = smp - hold_q;
                step     = gap >> sh;
                hold_nxt = capture ? smp : (hold_q + step);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)      hold_q <= RST_VAL;
        else if (vld) hold_q <= hold_nxt;
    end
endmodule

// File: rtl/mdet_avg.sv
`timescale 1ns/1ps
module mdet_avg #(
    parameter int DW    = 8,
    parameter int SHIFT = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld,
    input  logic [DW-1:0] env,
    output logic [DW-1:0] avg_q
);
    localparam int AW = DW + SHIFT;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_nxt;

    always_comb begin
        acc_nxt = acc_q - (acc_q >> SHIFT) + {{SHIFT{1'b0}}, env};
        avg_q   = acc_q[AW-1:SHIFT];
    end

    always_ff @(posedge clk) begin
        if (rst)      acc_q <= '0;
        else if (vld) acc_q <= acc_nxt;
    end
endmodule

// File: rtl/mdet_cmp.sv
`timescale 1ns/1ps
module mdet_cmp
    import mdet_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld,
    input  logic [DW-1:0] env,
    input  logic [DW-1:0] avg,
    input  sens_e         sens,
    output logic          flag_q
);
    logic [DW-1:0] half, quarter, eighth, thr;

    always_comb begin
        half    = avg >> 1;
        quarter = avg >> 2;
        eighth  = avg >> 3;
        unique case (sens)
            SENS_HALF: thr = half;
            SENS_5_8:  thr = half + eighth;
            SENS_3_4:  thr = half + quarter;
            SENS_7_8:  thr = avg - eighth;
            default:   thr = half;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (vld) flag_q <= env < thr;
    end
endmodule

// File: rtl/mdet_top.sv
`timescale 1ns/1ps
module mdet_top
    import mdet_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_wdata,
    output logic          mirror_o
);
    cfg_t          cfg_q;
    logic [DW-1:0] pk_q, pk_nxt;
    logic [DW-1:0] bt_q, bt_nxt;
    logic [DW-1:0] env_nxt;
    logic [DW-1:0] avg_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '{speed: 2'd0, sens: SENS_HALF};
        else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
    end

    mdet_hold #(
        .DW(DW), .TRACK_MAX(1'b1),
        .FIXED_SHIFT(PEAK_DECAY_SHIFT), .BASE_SHIFT(BOT_BASE_SHIFT)
    ) u_peak (
        .clk(clk), .rst(rst), .vld(smp_vld), .smp(smp),
        .rate_sel(cfg_q.speed), .hold_q(pk_q), .hold_nxt(pk_nxt)
    );

    mdet_hold #(
        .DW(DW), .TRACK_MAX(1'b0),
        .FIXED_SHIFT(PEAK_DECAY_SHIFT), .BASE_SHIFT(BOT_BASE_SHIFT)
    ) u_bottom (
        .clk(clk), .rst(rst), .vld(smp_vld), .smp(smp),
        .rate_sel(cfg_q.speed), .hold_q(bt_q), .hold_nxt(bt_nxt)
    );

    always_comb begin
        env_nxt = (pk_nxt > bt_nxt) ? (pk_nxt - bt_nxt) : '0;
    end

    mdet_avg #(.DW(DW), .SHIFT(AVG_SHIFT)) u_avg (
        .clk(clk), .rst(rst), .vld(smp_vld), .env(env_nxt), .avg_q(avg_q)
    );

    mdet_cmp #(.DW(DW)) u_cmp (
        .clk(clk), .rst(rst), .vld(smp_vld), .env(env_nxt),
        .avg(avg_q), .sens(cfg_q.sens), .flag_q(mirror_o)
    );
endmodule

// File: rtl/mdet_chk.sv
`timescale 1ns/1ps
module mdet_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          smp_vld,
    input logic [DW-1:0] smp,
    input logic [DW-1:0] pk_q,
    input logic [DW-1:0] bt_q,
    input logic          mirror_o
);
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(mirror_o)); // R2

    AST_TRACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(pk_q) && $stable(bt_q))); // R2

    AST_PEAK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && smp > pk_q) |=> pk_q == $past(smp)); // R3

    AST_PEAK_DECAY: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && smp <= pk_q) |=> (pk_q <= $past(pk_q) && pk_q >= $past(smp))); // R3

    AST_BOT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && smp < bt_q) |=> bt_q == $past(smp)); // R4

    AST_BOT_RISE: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && smp >= bt_q) |=> (bt_q >= $past(bt_q) && bt_q <= $past(smp))); // R4

    AST_ORDER: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> pk_q >= bt_q); // R5
endmodule

bind mdet_top mdet_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(smp),
    .pk_q(pk_q), .bt_q(bt_q), .mirror_o(mirror_o)
);

// File: tb/sim_mdet_top.sv
`timescale 1ns/1ps
module sim_mdet_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_vld = 1'b0;
    logic [7:0] smp = 8'd0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = 4'd0;
    logic       mirror_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model state
    int m_pk, m_bt, m_acc, m_speed, m_sens;
    bit m_flag;

    always #2.5 clk = ~clk;

    mdet_top #(.DW(8)) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(smp),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .mirror_o(mirror_o)
    );

    task automatic check(input string tag, input bit exp);
        n_vec++;
        if (mirror_o !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t mirror_o=%b expected=%b", tag, $time, mirror_o, exp);
        end
    endtask

    function automatic int thr_of(input int a, input int s);
        case (s)
            0: return (a >> 1);
            1: return (a >> 1) + (a >> 3);
            2: return (a >> 1) + (a >> 2);
            default: return a - (a >> 3);
        endcase
    endfunction

    // R3 R4 R5 R6 R7 R8: one strobe through the model
    function automatic void model_step(input int s);
        int env, thr;
        if (s > m_pk) m_pk = s; else m_pk = m_pk - ((m_pk - s) >> 4);
        if (s < m_bt) m_bt = s; else m_bt = m_bt + ((s - m_bt) >> (2 + m_speed));
        env = m_pk - m_bt;
        thr = thr_of(m_acc >> 6, m_sens);
        m_flag = (env < thr);
        m_acc = m_acc - (m_acc >> 6) + env;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_vld = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_pk = 0; m_bt = 255; m_acc = 0; m_speed = 0; m_sens = 0; m_flag = 1'b0;
        check("R1 reset flag", 1'b0);
    endtask

    task automatic write_cfg(input int spd, input int sns);
        cfg_we = 1'b1; cfg_wdata = 4'((spd << 2) | sns);
        @(negedge clk);
        cfg_we = 1'b0;
        m_speed = spd; m_sens = sns;
    endtask

    // strobe one sample; check flag in the following cycle
    task automatic send(input int s, input bit idle_after);
        smp_vld = 1'b1; smp = 8'(s);
        model_step(s);
        @(negedge clk);
        smp_vld = 1'b0; smp = 8'd77;
        check("R3/R4/R5/R6/R7/R8 flag after strobe", m_flag);
        if (idle_after) begin
            @(negedge clk);
            check("R2 flag held between strobes", m_flag);
        end
    endtask

    function automatic int pattern(input int i);
        int ph;
        ph = i % 48;
        if (ph < 30) return (i % 2) ? 230 : 25;
        return 128 + ((i % 2) * 3);
    endfunction

    initial begin
        logic [15:0] lfsr;
        do_reset();
        // R1: first strobe after reset with sample 0
        send(0, 1'b1);

        // R4 R7 R8: sweep every speed/sensitivity pair over a burst pattern
        for (int spd = 0; spd < 4; spd++) begin
            for (int sns = 0; sns < 4; sns++) begin
                do_reset();
                write_cfg(spd, sns);
                for (int i = 0; i < 300; i++) send(pattern(i), (i % 7) == 3);
            end
        end

        // R9: settings written on the same edge as a strobe
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            int s;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = ((i / 40) % 2) ? (120 + (lfsr[2:0])) : lfsr[7:0];
            if ((i % 53) == 17) begin
                int spd, sns;
                spd = lfsr[9:8]; sns = lfsr[11:10];
                cfg_we = 1'b1; cfg_wdata = 4'((spd << 2) | sns);
                smp_vld = 1'b1; smp = 8'(s);
                model_step(s);       // old settings apply on this edge
                m_speed = spd; m_sens = sns;
                @(negedge clk);
                cfg_we = 1'b0; smp_vld = 1'b0;
                check("R9 same-edge write uses old settings", m_flag);
            end else begin
                send(s, (i % 11) == 5);
            end
        end

        // R1: reset in the middle of a run clears the flag
        do_reset();
        send(200, 1'b0);
        send(200, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired mirror_o=%b expected=finish", mirror_o);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule